// File: doc/BRIEF.md
# Interval / Capture Timer Channel

This block is one timer channel with two counting behaviours. In interval mode it loads a reload value, counts down to zero and then raises a one-clock interrupt, optionally toggles an output pin, and reloads. The period is reload+1 clocks. In capture mode it counts up from zero. When a chosen edge appears on a capture input, it stores the running count, raises an interrupt and restarts from zero. Two further mode codes make the counter run freely with no interrupt and no pin activity.

A per-channel start-interrupt enable sets what happens when counting begins. When it is set, the start of counting acts like a completed cycle: an interrupt is raised at once and, in interval mode, the pin toggles. When it is clear, the start is silent, and the first interrupt arrives only after one full period. Configuration arrives on plain parallel inputs. A single level input starts and stops the count.

Top module: `tmr_chan`

## Requirements
- R1: While reset is asserted and right after it, `irq` is 0, `tout` is 0 and `cap_val` is 0.
- R2: A start is the first clock edge that samples `run_en` at 1 after an edge that sampled it at 0. In modes 0 (interval) and 1 (capture) with `start_irq_en`=1, `irq` is high for the clock cycle that follows the start edge.
- R3: With `start_irq_en`=0, the start edge produces no `irq` and leaves `tout` unchanged. In interval mode the first `irq` follows the edge that comes reload+1 edges after the start edge.
- R4: In interval mode (`mode`=0), while running, `irq` pulses exactly once every reload+1 clocks, counted from the start edge. This holds for every reload value, including 0, which gives a pulse every clock.
- R5: In interval mode, `tout` inverts on every `irq` pulse, the start pulse included, when `out_en`=1. When `out_en`=0, `tout` never changes.
- R6: In capture mode (`mode`=1) the count is 0 after the start edge and rises by 1 per clock. The selected edge is rising when `cap_edge_sel`=0 and falling when it is 1. On the first clock that sees `cap_in` at the new level, `cap_val` takes the count held before that clock, `irq` pulses and the count returns to 0. The opposite edge does nothing.
- R7: In capture mode, `tout` never changes, whatever `start_irq_en` and `out_en` are.
- R8: In modes 2 and 3, `irq` stays 0 and `tout` stays unchanged, including at start, whatever `start_irq_en` and `out_en` are.
- R9: While `run_en` is 0, `irq` stays 0 and `tout` holds its level. Raising `run_en` again is a new start.
- R10: A selected capture edge seen on the start edge itself is ignored. `cap_val` keeps its value, and the only `irq` is the start interrupt given by `start_irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Count enable; a rising level starts counting |
| mode | input | 2 | 0 interval, 1 capture, 2/3 free count |
| reload_val | input | CNT_W | Interval reload value |
| start_irq_en | input | 1 | Interrupt (and interval toggle) at count start |
| out_en | input | 1 | Lets interval events toggle `tout` |
| cap_in | input | 1 | Capture input |
| cap_edge_sel | input | 1 | 0 rising, 1 falling capture edge |
| irq | output | 1 | One-clock interrupt pulse |
| tout | output | 1 | Toggle output pin |
| cap_val | output | CNT_W | Last captured count |

## Verification
Two events can land on the same clock edge: the start of counting and a capture edge. The bench changes `cap_in` to its active level in the same half-cycle that it raises `run_en`, for both edge polarities and both settings of `start_irq_en`. It then requires that `cap_val` keeps its earlier value, that `irq` matches only the start-interrupt setting, and that no late capture follows on the next clock. The interval sweep also covers reload 0 with the start interrupt enabled. There, the start pulse and the first expiry fall on back-to-back edges, and the bench expects two separate pulses and two toggles.

// File: rtl/tmr_chan_pkg.sv
package tmr_chan_pkg;

   typedef enum logic [1:0] {
      MODE_INTERVAL = 2'd0,
      MODE_CAPTURE  = 2'd1,
      MODE_FREE     = 2'd2,
      MODE_FREE_ALT = 2'd3
   } mode_e;

   function automatic logic mode_has_irq(mode_e m);
      return (m == MODE_INTERVAL) || (m == MODE_CAPTURE);
   endfunction

endpackage

// File: rtl/tmr_run_ctl.sv
module tmr_run_ctl (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   output logic start,
   output logic active
);
   logic run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= run_en;
   end

   assign start  = run_en & ~run_q;
   assign active = run_en &  run_q;
endmodule

// File: rtl/tmr_cap_edge.sv
module tmr_cap_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cap_in,
   input  logic edge_sel,
   output logic hit
);
   logic cap_s;
   logic prev_q;

   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("tmr_cap_edge: SYNC_STAGES must be 0..4");
      end
      if (SYNC_STAGES == 0) begin : g_direct
         assign cap_s = cap_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-1:0], cap_in} >> 0;
         end
         assign cap_s = chain_q[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= cap_s;
   end

   assign hit = edge_sel ? (prev_q & ~cap_s) : (~prev_q & cap_s);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             active,
   input  mode_e            mode,
   input  logic [CNT_W-1:0] reload,
   input  logic             start_irq_en,
   input  logic             cap_hit,
   output logic [CNT_W-1:0] cap_val,
   output logic             evt,
   output logic             tog
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_d, cap_d;

   always_comb begin
      cnt_d = cnt_q;
      cap_d = cap_val;
      evt   = 1'b0;
      tog   = 1'b0;
      if (start) begin
         case (mode)
            MODE_INTERVAL: begin
               cnt_d = reload;
               evt   = start_irq_en;
               tog   = start_irq_en;
            end
            MODE_CAPTURE: begin
               cnt_d = '0;
               evt   = start_irq_en;
            end
            default: cnt_d = '0;
         endcase
      end else if (active) begin
         case (mode)
            MODE_INTERVAL: begin
               if (cnt_q == '0) begin
                  cnt_d = reload;
                  evt   = 1'b1;
                  tog   = 1'b1;
               end else begin
                  cnt_d = cnt_q - ONE;
               end
            end
            MODE_CAPTURE: begin
               if (cap_hit) begin
                  cap_d = cnt_q;
                  cnt_d = '0;
                  evt   = 1'b1;
               end else begin
                  cnt_d = cnt_q + ONE;
               end
            end
            default: cnt_d = cnt_q + ONE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         cap_val <= '0;
      end else begin
         cnt_q   <= cnt_d;
         cap_val <= cap_d;
      end
   end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
   import tmr_chan_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [1:0]       mode,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             start_irq_en,
   input  logic             out_en,
   input  logic             cap_in,
   input  logic             cap_edge_sel,
   output logic             irq,
   output logic             tout,
   output logic [CNT_W-1:0] cap_val
);
   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("tmr_chan: CNT_W must be 2..32");
      end
   endgenerate

   logic start, active, cap_hit, core_evt, core_tog;

   tmr_run_ctl run_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_en (run_en),
      .start  (start),
      .active (active)
   );

   tmr_cap_edge #(.SYNC_STAGES(SYNC_STAGES)) edge_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_in   (cap_in),
      .edge_sel (cap_edge_sel),
      .hit      (cap_hit)
   );

   tmr_count_core #(.CNT_W(CNT_W)) core_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .active       (active),
      .mode         (mode_e'(mode)),
      .reload       (reload_val),
      .start_irq_en (start_irq_en),
      .cap_hit      (cap_hit),
      .cap_val      (cap_val),
      .evt          (core_evt),
      .tog          (core_tog)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq  <= 1'b0;
         tout <= 1'b0;
      end else begin
         irq  <= core_evt;
         tout <= tout ^ (core_tog & out_en);
      end
   end
endmodule

// File: rtl/tmr_chan_chk.sv
module tmr_chan_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic [1:0]       mode,
   input logic             start_irq_en,
   input logic             out_en,
   input logic             irq,
   input logic             tout,
   input logic [CNT_W-1:0] cap_val
);
   // R2
   start_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(run_en) && start_irq_en && mode[1] == 1'b0) |=> irq);

   // R3
   quiet_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(run_en) && !start_irq_en) |=> (!irq && $stable(tout)));

   // R5
   out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en |=> $stable(tout));

   // R7
   cap_no_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd1) |=> $stable(tout));

   // R8
   free_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode[1] |=> (!irq && $stable(tout)));

   // R9
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> (!irq && $stable(tout)));

   // R6
   cap_with_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_val) |-> irq);
endmodule

bind tmr_chan tmr_chan_chk #(.CNT_W(CNT_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .run_en       (run_en),
   .mode         (mode),
   .start_irq_en (start_irq_en),
   .out_en       (out_en),
   .irq          (irq),
   .tout         (tout),
   .cap_val      (cap_val)
);

// File: tb/tmr_chan_tb_top.sv
module tmr_chan_tb_top;
   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         run_en = 1'b0;
   logic [1:0]   mode = 2'd0;
   logic [W-1:0] reload_val = '0;
   logic         start_irq_en = 1'b0;
   logic         out_en = 1'b0;
   logic         cap_in = 1'b0;
   logic         cap_edge_sel = 1'b0;
   logic         irq, tout;
   logic [W-1:0] cap_val;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   tmr_chan #(.CNT_W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode(mode),
      .reload_val(reload_val), .start_irq_en(start_irq_en), .out_en(out_en),
      .cap_in(cap_in), .cap_edge_sel(cap_edge_sel),
      .irq(irq), .tout(tout), .cap_val(cap_val)
   );

   task automatic check(string req, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic stop_and_config(logic [1:0] m, int rl, logic sie, logic oe);
      @(negedge clk);
      run_en = 1'b0;
      mode = m;
      reload_val = W'(rl);
      start_irq_en = sie;
      out_en = oe;
      @(negedge clk);
      check("R9 stopped irq", irq, 0);
   endtask

   task automatic run_interval(int rl, logic sie, logic oe);
      logic exp_t;
      stop_and_config(2'd0, rl, sie, oe);
      exp_t = tout;
      run_en = 1'b1;
      for (int j = 0; j <= 3 * (rl + 1) + 1; j++) begin
         logic exp_i;
         @(negedge clk);
         exp_i = (j == 0) ? sie : ((j % (rl + 1)) == 0);
         if (exp_i && oe) exp_t = ~exp_t;
         if (j == 0) begin
            check("R2/R3 start irq", irq, exp_i);
            check("R3/R5 start tout", tout, exp_t);
         end else begin
            check("R4 interval irq", irq, exp_i);
            check("R5 interval tout", tout, exp_t);
         end
      end
      run_en = 1'b0;
      repeat (3) begin
         @(negedge clk);
         check("R9 hold irq", irq, 0);
         check("R9 hold tout", tout, exp_t);
      end
   endtask

   task automatic run_capture(int k, logic sel, logic sie);
      logic t0;
      logic [W-1:0] c0;
      stop_and_config(2'd1, 5, sie, 1'b1);
      cap_edge_sel = sel;
      cap_in = sel;
      @(negedge clk);
      t0 = tout;
      run_en = 1'b1;
      @(negedge clk);
      check("R2 capture start irq", irq, sie);
      for (int j = 1; j <= k; j++) begin
         if (j == k) cap_in = ~sel;
         c0 = cap_val;
         @(negedge clk);
         check("R6 capture irq", irq, (j == k) ? 1 : 0);
         if (j == k) check("R6 capture value", cap_val, k - 1);
         else        check("R6 capture held", cap_val, c0);
      end
      cap_in = sel;
      repeat (3) begin
         @(negedge clk);
         check("R6 opposite edge irq", irq, 0);
         check("R6 opposite edge value", cap_val, k - 1);
      end
      check("R7 capture tout", tout, t0);
   endtask

   task automatic run_start_collision(logic sel, logic sie);
      logic [W-1:0] c0;
      stop_and_config(2'd1, 0, sie, 1'b1);
      cap_edge_sel = sel;
      cap_in = sel;
      @(negedge clk);
      c0 = cap_val;
      run_en = 1'b1;
      cap_in = ~sel;
      @(negedge clk);
      check("R10 collision irq", irq, sie);
      check("R10 collision value", cap_val, c0);
      @(negedge clk);
      check("R10 no late capture", irq, 0);
      check("R10 value kept", cap_val, c0);
   endtask

   task automatic run_free(logic [1:0] m);
      logic t0;
      stop_and_config(m, 2, 1'b1, 1'b1);
      t0 = tout;
      run_en = 1'b1;
      repeat (12) begin
         cap_in = ~cap_in;
         @(negedge clk);
         check("R8 free irq", irq, 0);
         check("R8 free tout", tout, t0);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset irq", irq, 0);
      check("R1 reset tout", tout, 0);
      check("R1 reset cap_val", cap_val, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset irq", irq, 0);
      check("R1 after reset tout", tout, 0);

      for (int rl = 0; rl < 8; rl++)
         for (int s = 0; s < 2; s++)
            for (int o = 0; o < 2; o++)
               run_interval(rl, s[0], o[0]);

      for (int k = 1; k <= 10; k++)
         for (int sel = 0; sel < 2; sel++)
            for (int s = 0; s < 2; s++)
               run_capture(k, sel[0], s[0]);

      for (int sel = 0; sel < 2; sel++)
         for (int s = 0; s < 2; s++)
            run_start_collision(sel[0], s[0]);

      run_free(2'd2);
      run_free(2'd3);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule